// File: doc/BRIEF.md
# Oldest-Eligible Age Selector

This block arbitrates among `N` requesters, such as warp slots or queue entries, and always favours the one that has waited longest since it was last served. It does not store timestamps. It keeps an `N` x `N` bit relation. Bit `[i][j]` is set when entry `i` was granted more recently than entry `j`. The number of ones in a row is therefore the number of entries that the row's owner is younger than. The row with the smallest count belongs to the oldest entry.

Each cycle the caller presents an eligibility mask. The block answers in the same cycle with a one-hot grant, the binary index of that grant, and a valid flag. When the select strobe is high and some entry is eligible, the grant is taken on the rising edge and the relation is updated. The granted entry's row is filled with ones, and its column is cleared in every row. That entry becomes the youngest. With two entries the relation reduces to one meaningful bit, and the grant alternates between the two.

Top module: `age_matrix_sel`

## Requirements
- R1: The relation is cleared by a synchronous active-high `rst`. In the first cycle after reset, with all entries eligible, the grant is index 0.
- R2: Only entries whose `elig_mask` bit is 1 can be granted. With an all-zero mask, `grant_vld` is 0 and `grant_oh` is 0.
- R3: The grant goes to the eligible entry whose most recent grant lies furthest in the past. An entry that has never been granted counts as older than any entry that has been granted.
- R4: Among eligible entries with equal age, which happens only for never-granted entries, the lowest index wins.
- R5: After a taken grant of entry k, entry k is the youngest of all entries. It will not be chosen again while any other entry is eligible.
- R6: When `sel_en` is 0 or no entry is eligible, the clock edge leaves the ages unchanged, so the same inputs produce the same grant on the next cycle.
- R7: `grant_oh`, `grant_idx` and `grant_vld` are combinational from the current ages and `elig_mask`. The age update takes effect at the next rising edge.
- R8: `grant_oh` has at most one bit set, `grant_vld` equals the OR of `grant_oh`, and when it is valid, bit `grant_idx` of `grant_oh` is the set bit.
- R9: With N = 2, both entries eligible and `sel_en` held high, the grants alternate 0, 1, 0, 1, ...

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| elig_mask | input | N | Entry i may be granted when bit i is 1 |
| sel_en | input | 1 | Take the current grant at the next edge |
| grant_oh | output | N | One-hot grant of the oldest eligible entry |
| grant_idx | output | IW = clog2(N) | Binary index of the grant |
| grant_vld | output | 1 | A grant is present this cycle |

## Verification
A corrupted relation bit changes the order of two entries. The fault shows at the ports on the first cycle in which both entries are eligible and one of them is the oldest, so it can stay hidden until the mask singles them out. A faulty update after a grant shows on the very next cycle when all entries are eligible, because the just-granted entry would be picked again or the wrong older entry would win. For this reason the bench mixes full masks, single-entry masks and random masks, and it compares against a last-grant timestamp model on every cycle.

// File: rtl/age_sel_pkg.sv
package age_sel_pkg;
  // width needed to hold a population count of 0..n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

  // width of a binary index into n entries (at least one bit)
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/age_rel_store.sv
module age_rel_store #(
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd,
  input  logic [N-1:0]        sel_oh,
  output logic [N-1:0][N-1:0] rel
);
  // row r, bit c = 1 : entry r granted after entry c
  for (genvar r = 0; r < N; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        rel[r] <= '0;
      end else if (upd) begin
        if (sel_oh[r]) rel[r] <= ~sel_oh;      // whole row set, own column cleared
        else           rel[r] <= rel[r] & ~sel_oh;
      end
    end
  end

  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(rel));

  p_update_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    upd |-> $onehot(sel_oh));
endmodule

// File: rtl/age_row_count.sv
module age_row_count #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]  row,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int b = 0; b < N; b++) cnt = cnt + CW'(row[b]);
  end
endmodule

// File: rtl/age_oldest_pick.sv
module age_oldest_pick #(
  parameter int N  = 8,
  parameter int CW = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0][CW-1:0] cnts,
  input  logic [N-1:0]         elig,
  output logic [N-1:0]         pick_oh,
  output logic [IW-1:0]        pick_idx,
  output logic                 pick_vld
);
  logic [CW-1:0] best;

  // strict "<" keeps the first (lowest) index on equal counts
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    best     = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!pick_vld || cnts[i] < best)) begin
        pick_vld = 1'b1;
        pick_idx = IW'(i);
        best     = cnts[i];
      end
    end
    pick_oh = '0;
    if (pick_vld) pick_oh[pick_idx] = 1'b1;
  end
endmodule

// File: rtl/age_matrix_sel.sv
module age_matrix_sel #(
  parameter  int N  = 8,
  localparam int IW = age_sel_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig_mask,
  input  logic          sel_en,
  output logic [N-1:0]  grant_oh,
  output logic [IW-1:0] grant_idx,
  output logic          grant_vld
);
  localparam int CW = age_sel_pkg::cnt_w(N);

  logic [N-1:0][N-1:0]  rel;
  logic [N-1:0][CW-1:0] cnts;
  logic                 take;

  assign take = sel_en && grant_vld;

  age_rel_store #(.N(N)) u_store (
    .clk    (clk),
    .rst    (rst),
    .upd    (take),
    .sel_oh (grant_oh),
    .rel    (rel)
  );

  for (genvar r = 0; r < N; r++) begin : g_cnt
    age_row_count #(.N(N), .CW(CW)) u_cnt (
      .row (rel[r]),
      .cnt (cnts[r])
    );
  end

  age_oldest_pick #(.N(N), .CW(CW), .IW(IW)) u_pick (
    .cnts     (cnts),
    .elig     (elig_mask),
    .pick_oh  (grant_oh),
    .pick_idx (grant_idx),
    .pick_vld (grant_vld)
  );

  p_only_eligible_r2: assert property (@(posedge clk) disable iff (rst)
    (grant_oh & ~elig_mask) == '0);

  p_none_eligible_r2: assert property (@(posedge clk) disable iff (rst)
    (elig_mask == '0) |-> !grant_vld);

  p_grant_shape_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_oh) && (grant_vld == (grant_oh != '0)));

  p_index_match_r8: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> grant_oh[grant_idx]);

  p_taken_is_youngest_r5: assert property (@(posedge clk) disable iff (rst)
    take |=> cnts[$past(grant_idx)] == CW'(N - 1));
endmodule

// File: tb/age_matrix_sel_tb.sv
module age_matrix_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NA-1:0] mask = '0;
  logic          en = 1'b0;
  logic [NA-1:0] goh_a;
  logic [2:0]    gidx_a;
  logic          gvld_a;
  logic [NB-1:0] goh_b;
  logic [0:0]    gidx_b;
  logic          gvld_b;

  int checks = 0;
  int fails  = 0;
  int ts_a [NA];
  int ts_b [NB];
  int now_a = 0;
  int now_b = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  age_matrix_sel #(.N(NA)) u_dut (
    .clk(clk), .rst(rst), .elig_mask(mask), .sel_en(en),
    .grant_oh(goh_a), .grant_idx(gidx_a), .grant_vld(gvld_a));

  age_matrix_sel #(.N(NB)) u_dut2 (
    .clk(clk), .rst(rst), .elig_mask(mask[NB-1:0]), .sel_en(en),
    .grant_oh(goh_b), .grant_idx(gidx_b), .grant_vld(gvld_b));

  function automatic int pick_a(input logic [NA-1:0] m);
    int best = -1;
    for (int i = 0; i < NA; i++)
      if (m[i] && (best < 0 || ts_a[i] < ts_a[best])) best = i;
    return best;
  endfunction

  function automatic int pick_b(input logic [NB-1:0] m);
    int best = -1;
    for (int i = 0; i < NB; i++)
      if (m[i] && (best < 0 || ts_b[i] < ts_b[best])) best = i;
    return best;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NA; i++) ts_a[i] = -1;
    for (int i = 0; i < NB; i++) ts_b[i] = -1;
  endtask

  // drive at negedge, compare 1 time unit later, let the edge update the model
  task automatic step(input logic [NA-1:0] m, input logic e, input string tag);
    int ea, eb;
    logic [NA-1:0] oh_a;
    logic [NB-1:0] oh_b;
    @(negedge clk);
    mask = m;
    en   = e;
    #1;
    ea = pick_a(m);
    eb = pick_b(m[NB-1:0]);
    oh_a = (ea >= 0) ? (NA'(1) << ea) : '0;
    oh_b = (eb >= 0) ? (NB'(1) << eb) : '0;
    checks++;
    if (gvld_a !== (ea >= 0) || goh_a !== oh_a || (ea >= 0 && gidx_a !== 3'(ea))) begin
      fails++;
      $display("FAIL %s N=8 mask=%b: got vld=%b oh=%b idx=%0d, expected vld=%0d oh=%b idx=%0d",
               tag, m, gvld_a, goh_a, gidx_a, ea >= 0, oh_a, ea);
    end
    checks++;
    if (gvld_b !== (eb >= 0) || goh_b !== oh_b || (eb >= 0 && gidx_b !== 1'(eb))) begin
      fails++;
      $display("FAIL %s N=2 mask=%b: got vld=%b oh=%b idx=%0d, expected vld=%0d oh=%b idx=%0d",
               tag, m[NB-1:0], gvld_b, goh_b, gidx_b, eb >= 0, oh_b, eb);
    end
    @(posedge clk);
    if (e && ea >= 0) ts_a[ea] = now_a++;
    if (e && eb >= 0) ts_b[eb] = now_b++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, all entries equal, index 0 wins
    step('1, 1'b0, "R1");
    // R7: grant visible before any edge, held without sel_en (R6)
    step('1, 1'b0, "R6/R7");
    // R4/R3/R5: full mask serves 0..7 in order; R9: N=2 alternates
    for (int k = 0; k < NA; k++) step('1, 1'b1, "R3/R4/R5/R9");
    // R5: a fresh round repeats the same order
    for (int k = 0; k < 4; k++) step('1, 1'b1, "R5/R9");
    // R2: empty mask, no grant and no change (R6)
    step('0, 1'b1, "R2");
    step('1, 1'b0, "R6");
    // R2: a single eligible entry always wins
    step(8'b0100_0000, 1'b1, "R2");
    step(8'b0100_0000, 1'b0, "R2");
    // R3: oldest among a subset
    step(8'b1011_0110, 1'b1, "R3");
    step(8'b1011_0110, 1'b1, "R3");
    // R6: sel_en low over several cycles leaves ages unchanged
    for (int k = 0; k < 3; k++) step(8'b1111_0000, 1'b0, "R6");
    // R1: reset in mid run restores the initial order
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    step('1, 1'b1, "R1");
    step(8'b0000_0011, 1'b1, "R4/R9");
    // R3/R8: random masks and strobes
    for (int k = 0; k < 400; k++)
      step(NA'($urandom), ($urandom % 4) != 0, "R3/R8");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule